// File: doc/BRIEF.md
# Programmable Threshold Offset Loader with Almost-Full/Almost-Empty Flags

This block sits next to a dual-clock FIFO core and holds the two thresholds that drive its early-warning flags. Software or a host loads the thresholds one byte at a time through the FIFO's own 8-bit data input. A single active-low load strobe, qualified by the write enable, steps a wrap-around selector through four byte-wide registers. The same strobe, qualified by two read enables, reads the registers back on the 8-bit output bus in the same rotating order. Loading may stop after any byte. The next load continues with the byte that follows the last one written.

The FIFO core supplies its occupancy count twice, once already synchronized into each clock domain. The block compares the occupancy in the read domain against the empty threshold and registers an active-low almost-empty flag on the read clock. It compares the free space in the write domain (depth minus occupancy) against the full threshold and registers an active-low almost-full flag on the write clock. The thresholds are quasi-static configuration: they are changed only while the FIFO is idle.

Top module: `flag_offset_seq`

## Requirements
- R1: The four offset bytes have selector indices 0 = empty threshold low byte, 1 = empty threshold high byte, 2 = full threshold low byte and 3 = full threshold high byte. The empty threshold is {byte1, byte0} and the full threshold is {byte3, byte2}.
- R2: On a rising wr_clk edge with load_n = 0 and wr_en_n = 0, wr_data is stored in the byte at the write selector, and the selector advances by one, wrapping from 3 to 0. With load_n = 1 or wr_en_n = 1, no offset byte changes.
- R3: Loading may pause for any number of cycles after any byte. The next load writes the byte that follows the last one written.
- R4: On a rising rd_clk edge with load_n = 0, rd_en_a_n = 0, rd_en_b_n = 0 and wr_en_n = 1, rd_data takes the byte at the read selector, and that selector advances in the same order, wrapping from 3 to 0. Otherwise rd_data and the read selector hold.
- R5: Reset (rst_n = 0, asynchronous) sets every offset to 7 (bytes 0x07, 0x00, 0x07, 0x00), clears both selectors to index 0 and rd_data to 0, drives almost_full_n to 1 and drives almost_empty_n to 0.
- R6: almost_empty_n is registered on rd_clk. Each rising rd_clk edge sets it to 0 if rd_count is at or below the empty threshold, and to 1 otherwise.
- R7: almost_full_n is registered on wr_clk. Each rising wr_clk edge sets it to 0 if DEPTH − wr_count is at or below the full threshold, and to 1 otherwise.
- R8: Only the low 10 bits of each 16-bit threshold take part in the comparisons. The upper six bits are stored and read back but have no effect on the flags.
- R9: A readback request that coincides with a load write (load_n, wr_en_n, rd_en_a_n and rd_en_b_n all 0) is dropped. The write takes effect, while rd_data and the read selector hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low offset access strobe |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| wr_data | input | 8 | Byte loaded into the selected offset |
| wr_count | input | CNT_W (11) | Occupancy, synchronized to wr_clk |
| rd_count | input | CNT_W (11) | Occupancy, synchronized to rd_clk |
| rd_data | output | 8 | Readback byte |
| almost_full_n | output | 1 | Active-low almost-full flag, wr_clk domain |
| almost_empty_n | output | 1 | Active-low almost-empty flag, rd_clk domain |

## Verification
The properties assume that the counts never exceed DEPTH. They also assume that the offsets change only while the flags are not being relied on, because the read domain samples bytes written in the write domain without a handshake. The stimulus drives one clock into both clock ports, so a load write and a readback can be placed on the same edge on purpose to exercise R9. Every input changes on the falling edge and stays stable across the rising edge that samples it. The counts stay between 0 and DEPTH.

// File: rtl/fos_pkg.sv
package fos_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // selector indices; the rotation order is behaviour
    localparam sel_t IDX_EMPTY_LO = sel_t'(0);
    localparam sel_t IDX_EMPTY_HI = sel_t'(1);
    localparam sel_t IDX_FULL_LO  = sel_t'(2);
    localparam sel_t IDX_FULL_HI  = sel_t'(3);

    function automatic sel_t sel_next(input sel_t s);
        return sel_t'(s + sel_t'(1));
    endfunction
endpackage

// File: rtl/fos_ofs_bank.sv
module fos_ofs_bank
    import fos_pkg::*;
#(
    parameter int OFS_W   = 10,
    parameter int DEF_OFS = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_n,
    input  logic                        wr_en_n,
    input  byte_t                       wr_data,
    output byte_t [NUM_REGS-1:0]        regs,
    output sel_t                        sel,
    output logic [OFS_W-1:0]            empty_ofs,
    output logic [OFS_W-1:0]            full_ofs
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam logic [PAIR_W-1:0] DEF_PAIR = PAIR_W'(DEF_OFS);

    typedef struct packed {
        sel_t                 sel;
        byte_t [NUM_REGS-1:0] regs;
    } bank_s;

    function automatic bank_s bank_reset();
        bank_s b;
        b.sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            b.regs[i] = DEF_PAIR[(i % 2) * BYTE_W +: BYTE_W];
        end
        return b;
    endfunction

    bank_s st_d, st_q;
    logic  load_hit;

    always_comb begin
        st_d     = st_q;
        load_hit = !load_n && !wr_en_n;
        if (load_hit) begin
            st_d.regs[st_q.sel] = wr_data;
            st_d.sel            = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= bank_reset();
        else        st_q <= st_d;
    end

    assign regs      = st_q.regs;
    assign sel       = st_q.sel;
    assign empty_ofs = OFS_W'({st_q.regs[IDX_EMPTY_HI], st_q.regs[IDX_EMPTY_LO]});
    assign full_ofs  = OFS_W'({st_q.regs[IDX_FULL_HI], st_q.regs[IDX_FULL_LO]});
endmodule

// File: rtl/fos_readback.sv
module fos_readback
    import fos_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_n,
    input  logic                 wr_en_n,
    input  logic                 rd_en_a_n,
    input  logic                 rd_en_b_n,
    input  byte_t [NUM_REGS-1:0] regs,
    output byte_t                rd_data,
    output sel_t                 sel
);
    typedef struct packed {
        sel_t  sel;
        byte_t data;
    } rb_s;

    rb_s  st_d, st_q;
    logic req, blocked;

    always_comb begin
        st_d    = st_q;
        req     = !load_n && !rd_en_a_n && !rd_en_b_n;
        blocked = !wr_en_n;   // a coincident load write wins
        if (req && !blocked) begin
            st_d.data = regs[st_q.sel];
            st_d.sel  = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;
    assign sel     = st_q.sel;
endmodule

// File: rtl/fos_flag_cmp.sv
module fos_flag_cmp #(
    parameter int DEPTH        = 1024,
    parameter int CNT_W        = 11,
    parameter int OFS_W        = 10,
    parameter bit MEASURE_FREE = 1'b0,
    parameter bit RST_VAL      = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [OFS_W-1:0] ofs,
    output logic             flag_n
);
    localparam int CMP_W = (CNT_W > OFS_W) ? CNT_W : OFS_W;

    typedef struct packed {
        logic flag_n;
    } flag_s;

    flag_s            st_d, st_q;
    logic [CNT_W-1:0] level;
    logic             hit;

    generate
        if (MEASURE_FREE) begin : g_free
            assign level = CNT_W'(DEPTH) - count;
        end else begin : g_fill
            assign level = count;
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        hit         = CMP_W'(level) <= CMP_W'(ofs);
        st_d.flag_n = !hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.flag_n <= RST_VAL;
        else        st_q        <= st_d;
    end

    assign flag_n = st_q.flag_n;
endmodule

// File: rtl/flag_offset_seq.sv
module flag_offset_seq
    import fos_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int OFS_W   = 10,
    parameter int DEF_OFS = 7,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             wr_en_n,
    input  logic             rd_en_a_n,
    input  logic             rd_en_b_n,
    input  logic [7:0]       wr_data,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [CNT_W-1:0] rd_count,
    output logic [7:0]       rd_data,
    output logic             almost_full_n,
    output logic             almost_empty_n
);
    byte_t [NUM_REGS-1:0] regs;
    sel_t                 wsel, rsel;
    logic [OFS_W-1:0]     empty_ofs, full_ofs;

    fos_ofs_bank #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_bank (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wr_en_n   (wr_en_n),
        .wr_data   (wr_data),
        .regs      (regs),
        .sel       (wsel),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    fos_readback u_rb (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wr_en_n   (wr_en_n),
        .rd_en_a_n (rd_en_a_n),
        .rd_en_b_n (rd_en_b_n),
        .regs      (regs),
        .rd_data   (rd_data),
        .sel       (rsel)
    );

    fos_flag_cmp #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W),
        .MEASURE_FREE(1'b1), .RST_VAL(1'b1)
    ) u_full (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .count  (wr_count),
        .ofs    (full_ofs),
        .flag_n (almost_full_n)
    );

    fos_flag_cmp #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W),
        .MEASURE_FREE(1'b0), .RST_VAL(1'b0)
    ) u_empty (
        .clk    (rd_clk),
        .rst_n  (rst_n),
        .count  (rd_count),
        .ofs    (empty_ofs),
        .flag_n (almost_empty_n)
    );
endmodule

// File: rtl/fos_checker.sv
module fos_checker #(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 11
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             wr_en_n,
    input logic             rd_en_a_n,
    input logic             rd_en_b_n,
    input logic [CNT_W-1:0] wr_count,
    input logic [CNT_W-1:0] rd_count,
    input logic [7:0]       rd_data,
    input logic             almost_full_n,
    input logic             almost_empty_n,
    input logic [1:0]       wsel,
    input logic [1:0]       rsel
);
    p_load_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!load_n && !wr_en_n) |=> (wsel == 2'($past(wsel) + 2'd1)));

    p_hold_between_loads_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (load_n || wr_en_n) |=> $stable(wsel));

    p_read_step_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!load_n && !rd_en_a_n && !rd_en_b_n && wr_en_n) |=> (rsel == 2'($past(rsel) + 2'd1)));

    p_read_idle_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (load_n || rd_en_a_n || rd_en_b_n) |=> ($stable(rd_data) && $stable(rsel)));

    p_empty_at_zero_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_count == '0) |=> !almost_empty_n);

    p_full_at_top_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_count == CNT_W'(DEPTH)) |=> !almost_full_n);

    p_write_wins_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!load_n && !wr_en_n && !rd_en_a_n && !rd_en_b_n) |=> ($stable(rd_data) && $stable(rsel)));
endmodule

bind flag_offset_seq fos_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .wr_clk         (wr_clk),
    .rd_clk         (rd_clk),
    .rst_n          (rst_n),
    .load_n         (load_n),
    .wr_en_n        (wr_en_n),
    .rd_en_a_n      (rd_en_a_n),
    .rd_en_b_n      (rd_en_b_n),
    .wr_count       (wr_count),
    .rd_count       (rd_count),
    .rd_data        (rd_data),
    .almost_full_n  (almost_full_n),
    .almost_empty_n (almost_empty_n),
    .wsel           (wsel),
    .rsel           (rsel)
);

// File: tb/sim_flag_offset_seq.sv
module sim_flag_offset_seq;
    localparam int DEPTH = 1024;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n, load_n, wr_en_n, rd_en_a_n, rd_en_b_n;
    logic [7:0]       wr_data;
    logic [CNT_W-1:0] wr_count, rd_count;
    logic [7:0]       rd_data;
    logic             almost_full_n, almost_empty_n;

    always #5 clk = ~clk;   // 100 MHz, drives both clock ports

    flag_offset_seq #(.DEPTH(DEPTH)) u0 (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .load_n(load_n), .wr_en_n(wr_en_n),
        .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
        .wr_data(wr_data), .wr_count(wr_count), .rd_count(rd_count),
        .rd_data(rd_data), .almost_full_n(almost_full_n),
        .almost_empty_n(almost_empty_n)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // requirement-level model
    logic [7:0] m [4];
    int         wp, rp;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m[0] = 8'h07; m[1] = 8'h00; m[2] = 8'h07; m[3] = 8'h00;
        wp = 0; rp = 0;
    endtask

    task automatic idle();
        load_n = 1'b1; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    endtask

    task automatic ld_wr(input logic [7:0] b);
        load_n = 1'b0; wr_en_n = 1'b0; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        wr_data = b;
        m[wp] = b; wp = (wp + 1) % 4;
        @(negedge clk);
        idle();
    endtask

    // driver: pushes the expected byte, monitor compares it
    task automatic rd(input string req);
        load_n = 1'b0; wr_en_n = 1'b1; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        exp_q.push_back(m[rp]); tag_q.push_back(req);
        rp = (rp + 1) % 4;
        @(negedge clk);
        idle();
    endtask

    always @(posedge clk) begin
        automatic bit go = rst_n && !load_n && !rd_en_a_n && !rd_en_b_n && wr_en_n;
        #2;
        if (go) begin
            if (exp_q.size() == 0) check("R4 unexpected read", rd_data, 0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic set_rd_count(input int c, input int exp_ae, input string req);
        rd_count = CNT_W'(c);
        @(negedge clk);
        check(req, almost_empty_n, exp_ae);
    endtask

    task automatic set_wr_count(input int c, input int exp_af, input string req);
        wr_count = CNT_W'(c);
        @(negedge clk);
        check(req, almost_full_n, exp_af);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        idle(); wr_data = '0; wr_count = '0; rd_count = '0; rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R5 reset almost_full_n", almost_full_n, 1);
        check("R5 reset almost_empty_n", almost_empty_n, 0);
        check("R5 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 flags after release af", almost_full_n, 1);
        check("R5 flags after release ae", almost_empty_n, 0);

        // defaults read back in R1 order
        repeat (4) rd("R5 default byte");

        // full load: empty = 0x0110, full = 0xFC20
        ld_wr(8'h10); ld_wr(8'h01); ld_wr(8'h20); ld_wr(8'hFC);
        repeat (4) rd("R1 R2 loaded byte");
        rd("R4 wrap to first");

        // no write without both strobes (R2)
        load_n = 1'b0; wr_en_n = 1'b1; wr_data = 8'hAA; @(negedge clk); idle();
        load_n = 1'b1; wr_en_n = 1'b0; wr_data = 8'hBB; @(negedge clk); idle();
        rd("R2 ignored write");

        // single read enable does nothing (R4)
        held = rd_data;
        load_n = 1'b0; rd_en_a_n = 1'b0; @(negedge clk); idle();
        load_n = 1'b0; rd_en_b_n = 1'b0; @(negedge clk); idle();
        check("R4 hold with one enable", rd_data, held);
        rd("R4 pointer unmoved");

        // flags: empty thr 272, full thr 0xFC20 -> 32 (R8)
        set_rd_count(272, 0, "R6 at empty threshold");
        set_rd_count(273, 1, "R6 above empty threshold");
        set_rd_count(0,   0, "R6 empty fifo");
        set_wr_count(992, 0, "R7 R8 free at full threshold");
        set_wr_count(991, 1, "R7 R8 free above full threshold");
        set_wr_count(DEPTH, 0, "R7 fifo full");
        set_wr_count(0, 1, "R7 fifo empty");

        // partial load then resume (R3)
        ld_wr(8'h03); ld_wr(8'h00);
        repeat (5) @(negedge clk);
        set_rd_count(3, 0, "R3 new empty threshold");
        set_rd_count(4, 1, "R3 above new empty threshold");
        ld_wr(8'h09);   // lands on full low byte
        set_wr_count(DEPTH - 9,  0, "R3 R8 resumed full low byte");
        set_wr_count(DEPTH - 10, 1, "R3 R8 above resumed threshold");

        // coincident load write and readback (R9)
        held = rd_data;
        load_n = 1'b0; wr_en_n = 1'b0; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        wr_data = 8'h44;
        m[wp] = 8'h44; wp = (wp + 1) % 4;
        @(negedge clk); idle();
        check("R9 read dropped", rd_data, held);
        rd("R9 write landed, pointer held");
        rd("R9 order continues");
        set_wr_count(DEPTH - 9, 0, "R8 upper byte ignored");

        // reset mid-run (R5)
        rst_n = 1'b0; #1;
        check("R5 mid reset af", almost_full_n, 1);
        check("R5 mid reset ae", almost_empty_n, 0);
        check("R5 mid reset rd_data", rd_data, 0);
        model_reset();
        @(negedge clk); rst_n = 1'b1; wr_count = '0; rd_count = 8;
        @(negedge clk);
        check("R5 R6 default empty threshold", almost_empty_n, 1);
        rd("R5 pointer back to first");
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule